// File: doc/BRIEF.md
# Full-Array Erase Sequencer

This block runs an erase of the whole array, one block at a time. A host writes a two-cycle command on a byte-wide command port. The first cycle arms the operation and the second cycle confirms it. The sequencer then visits every block in ascending index order. For each block it decides whether the block may be erased. A block is skipped only when its lock bit is set and the write-protect input is low. When write protect is high, lock bits are overridden.

Each block that may be erased is passed to an external erase engine through a start/done/fail handshake. A failure reported by the engine does not stop the walk. The failure is recorded in a per-block fail map and the walk moves on to the next block.

Progress and errors appear in an 8-bit status byte and on a ready output. An invalid confirm cycle, or a confirm while the programming supply is missing, raises error bits and erases nothing. While the walk runs, all command writes are ignored. This includes the suspend code, because a whole-array erase cannot be suspended.

Top module: `chip_erase_seq`

## Requirements
- R1: The walk starts only when the setup code 30h is followed, on the next accepted command write, by the confirm code D0h while `vpp_ok` is 1. On that confirm, `ready_out` and status bit 7 fall to 0. A D0h written without a preceding 30h starts nothing.
- R2: Blocks go to the engine in strictly ascending index order from 0 to NUM_BLK-1. A new `eng_start` is only issued after the previous block has returned `eng_done`.
- R3: With `wp_n` = 1, every block is started regardless of `lock_bits`. With `wp_n` = 0, a block whose lock bit is 1 is never started.
- R4: When the engine returns `eng_done` with `eng_fail` = 1, `fail_map[block]` is set and the walk continues with the next block. `fail_map` is cleared when a new walk starts.
- R5: If 30h is followed by any second cycle other than D0h, status bits 4 and 5 are set and no block is started.
- R6: A confirm while `vpp_ok` = 0 sets status bits 3 and 5, starts no block and leaves `fail_map` unchanged.
- R7: If any block fails, status bit 5 is 1 when the walk ends. If no block fails and no error was pending, the final status is 80h.
- R8: Command writes during the walk are ignored. This covers B0h (suspend), 50h, 30h and D0h: the walk and its outcome are unchanged.
- R9: `ready_out` (status bit 7) returns to 1 only in the cycle after the last block has been processed or skipped. After reset the status is 80h and `fail_map` is 0.
- R10: Code 50h written while idle clears status bits 3, 4 and 5 and leaves `fail_map` intact. Status bits 6, 2, 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command write strobe, one cycle per write |
| cmd_data | input | 8 | Command code |
| vpp_ok | input | 1 | Programming supply above lockout |
| wp_n | input | 1 | Write protect; 1 overrides lock bits |
| lock_bits | input | NUM_BLK | Per-block lock bit, 1 = locked |
| eng_start | output | 1 | One-cycle request to erase `eng_blk` |
| eng_blk | output | BLK_W | Index of the block being erased |
| eng_done | input | 1 | Engine finished the current block |
| eng_fail | input | 1 | Qualifies `eng_done`: the erase failed |
| fail_map | output | NUM_BLK | Per-block erase-fail flags |
| status | output | 8 | Bit 7 ready, bit 5 erase error, bit 4 sequence error, bit 3 supply error |
| ready_out | output | 1 | High when idle |

## Verification
The assertions check on every cycle the properties that hold step by step:
- the block index never goes back during a walk;
- no locked block is started while write protect is low;
- no two engine starts come back to back;
- no start is accepted while the walk is busy;
- a recorded failure lands on the reported block;
- ready rises only after the final block;
- the supply error bit never appears without the erase error bit.

Only the bench scenarios can show the outcome of a whole walk: that the set of started blocks matches the lock and write-protect rules, that the final fail map and status byte are correct, and that invalid sequences, missing supply, ignored mid-walk commands and the clear code have the described effect.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam logic [7:0] CODE_SETUP   = 8'h30;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_CLEAR   = 8'h50;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_CHECK = 2'd1,
    W_WAIT  = 2'd2
  } walk_st_t;

  // A block may be erased unless it is locked while protection is active.
  function automatic logic blk_erasable(input logic locked, input logic wp_high);
    return (!locked) || wp_high;
  endfunction

  // Status byte layout: 7 ready, 5 erase error, 4 sequence error, 3 supply error.
  function automatic logic [7:0] pack_status(input logic rdy, input logic e_erase,
                                             input logic e_seq, input logic e_vpp);
    return {rdy, 1'b0, e_erase, e_seq, e_vpp, 3'b000};
  endfunction
endpackage

// File: rtl/fce_cmd_dec.sv
module fce_cmd_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  input  logic       busy,
  input  logic       vpp_ok,
  output logic       start_evt,
  output logic       seq_err_evt,
  output logic       vpp_err_evt,
  output logic       clear_evt
);
  import fce_pkg::*;

  logic armed;
  logic accept;
  logic is_confirm;

  always_comb begin
    accept      = cmd_valid && !busy;
    is_confirm  = (cmd_data == CODE_CONFIRM);
    start_evt   = accept && armed && is_confirm && vpp_ok;
    vpp_err_evt = accept && armed && is_confirm && !vpp_ok;
    seq_err_evt = accept && armed && !is_confirm;
    clear_evt   = accept && !armed && (cmd_data == CODE_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (accept) armed <= armed ? 1'b0 : (cmd_data == CODE_SETUP);
  end

  // R8: a walk in progress never arms a new operation
  assert_no_arm_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !armed);
endmodule

// File: rtl/fce_walker.sv
module fce_walker #(
  parameter int NUM_BLK = 64,
  localparam int BW = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_evt,
  input  logic               wp_n,
  input  logic [NUM_BLK-1:0] lock_bits,
  input  logic               eng_done,
  input  logic               eng_fail,
  output logic               eng_start,
  output logic [BW-1:0]      eng_blk,
  output logic               busy,
  output logic               fail_evt,
  output logic               done_evt
);
  import fce_pkg::*;

  localparam logic [BW-1:0] LAST = BW'(NUM_BLK - 1);

  walk_st_t      state;
  logic [BW-1:0] blk;
  logic          skip_now;
  logic          step_evt;

  always_comb begin
    skip_now  = !blk_erasable(lock_bits[blk], wp_n);
    eng_start = (state == W_CHECK) && !skip_now;
    eng_blk   = blk;
    step_evt  = ((state == W_CHECK) && skip_now) || ((state == W_WAIT) && eng_done);
    done_evt  = step_evt && (blk == LAST);
    fail_evt  = (state == W_WAIT) && eng_done && eng_fail;
    busy      = (state != W_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      blk   <= '0;
    end else begin
      unique case (state)
        W_IDLE: if (start_evt) begin
          state <= W_CHECK;
          blk   <= '0;
        end
        W_CHECK: begin
          if (!skip_now) state <= W_WAIT;
          else if (blk == LAST) state <= W_IDLE;
          else blk <= blk + 1'b1;
        end
        W_WAIT: if (eng_done) begin
          if (blk == LAST) state <= W_IDLE;
          else begin
            blk   <= blk + 1'b1;
            state <= W_CHECK;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R2: index only moves forward within one walk
  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (blk >= $past(blk)));
  // R2: one block at a time, never two starts in a row
  assert_start_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R8: the decoder never launches while a walk runs
  assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (state == W_IDLE));
endmodule

// File: rtl/fce_fail_map.sv
module fce_fail_map #(
  parameter int NUM_BLK = 64,
  localparam int BW = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               set_evt,
  input  logic [BW-1:0]      set_idx,
  output logic [NUM_BLK-1:0] map
);
  for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map[i] <= 1'b0;
      else if (clr) map[i] <= 1'b0;
      else if (set_evt && (set_idx == BW'(i))) map[i] <= 1'b1;
    end
  end

  // R4: a reported failure is recorded on the reported block
  assert_fail_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !clr) |=> map[$past(set_idx)]);
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq #(
  parameter int NUM_BLK = 64,
  localparam int BW = $clog2(NUM_BLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_data,
  input  logic               vpp_ok,
  input  logic               wp_n,
  input  logic [NUM_BLK-1:0] lock_bits,
  output logic               eng_start,
  output logic [BW-1:0]      eng_blk,
  input  logic               eng_done,
  input  logic               eng_fail,
  output logic [NUM_BLK-1:0] fail_map,
  output logic [7:0]         status,
  output logic               ready_out
);
  import fce_pkg::*;

  logic busy, start_evt, seq_err_evt, vpp_err_evt, clear_evt, fail_evt, done_evt;
  logic err_erase, err_seq, err_vpp;

  fce_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(busy), .vpp_ok(vpp_ok), .start_evt(start_evt),
    .seq_err_evt(seq_err_evt), .vpp_err_evt(vpp_err_evt), .clear_evt(clear_evt)
  );

  fce_walker #(.NUM_BLK(NUM_BLK)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .wp_n(wp_n),
    .lock_bits(lock_bits), .eng_done(eng_done), .eng_fail(eng_fail),
    .eng_start(eng_start), .eng_blk(eng_blk), .busy(busy),
    .fail_evt(fail_evt), .done_evt(done_evt)
  );

  fce_fail_map #(.NUM_BLK(NUM_BLK)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(start_evt), .set_evt(fail_evt),
    .set_idx(eng_blk), .map(fail_map)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_erase <= 1'b0;
      err_seq   <= 1'b0;
      err_vpp   <= 1'b0;
    end else if (clear_evt) begin
      err_erase <= 1'b0;
      err_seq   <= 1'b0;
      err_vpp   <= 1'b0;
    end else begin
      if (seq_err_evt || vpp_err_evt || fail_evt) err_erase <= 1'b1;
      if (seq_err_evt) err_seq <= 1'b1;
      if (vpp_err_evt) err_vpp <= 1'b1;
    end
  end

  always_comb begin
    ready_out = !busy;
    status    = pack_status(!busy, err_erase, err_seq, err_vpp);
  end

  // R3: a locked block is never started while protection is active
  assert_lock_honoured_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !wp_n) |-> !lock_bits[eng_blk]);
  // R9: ready only returns after the final block was handled
  assert_ready_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_out) |-> $past(done_evt));
  // R6: supply error never stands without the erase error bit
  assert_vpp_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[5]);
endmodule

// File: tb/chip_erase_seq_tb.sv
module chip_erase_seq_tb;
  localparam int NB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic vpp_ok = 1'b1;
  logic wp_n = 1'b0;
  logic [NB-1:0] lock_bits = '0;
  logic eng_start;
  logic [5:0] eng_blk;
  logic eng_done = 1'b0;
  logic eng_fail = 1'b0;
  logic [NB-1:0] fail_map;
  logic [7:0] status;
  logic ready_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [NB-1:0] inject = '0;
  logic [NB-1:0] started = '0;
  int order_err = 0;
  int prev_blk = -1;

  always #4 clk = ~clk;

  chip_erase_seq #(.NUM_BLK(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .vpp_ok(vpp_ok), .wp_n(wp_n), .lock_bits(lock_bits), .eng_start(eng_start),
    .eng_blk(eng_blk), .eng_done(eng_done), .eng_fail(eng_fail),
    .fail_map(fail_map), .status(status), .ready_out(ready_out)
  );

  function automatic logic [NB-1:0] exp_mask(input logic [NB-1:0] lk, input logic wp);
    return wp ? {NB{1'b1}} : ~lk;
  endfunction

  function automatic logic [7:0] exp_stat(input logic rdy, input logic e5,
                                          input logic e4, input logic e3);
    logic [7:0] s;
    s = 8'h00;
    s[7] = rdy; s[5] = e5; s[4] = e4; s[3] = e3;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Erase engine model with random latency and per-block fail injection
  initial begin
    bit eb = 0;
    int cnt = 0;
    int b = 0;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      eng_fail = 1'b0;
      if (eb) begin
        if (cnt == 0) begin
          eng_done = 1'b1;
          eng_fail = inject[b];
          eb = 0;
        end else cnt--;
        if (eng_start) order_err++;
      end else if (eng_start) begin
        b = int'(eng_blk);
        if (b <= prev_blk) order_err++;
        prev_blk = b;
        started[b] = 1'b1;
        eb = 1;
        cnt = int'($urandom_range(0, 3));
      end
    end
  end

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready_out) @(negedge clk);
  endtask

  task automatic arm_run();
    started = '0;
    prev_blk = -1;
    order_err = 0;
  endtask

  // Full run with prior status cleared; checks R1, R2, R3, R4, R7
  task automatic run_full(input logic [NB-1:0] lk, input logic wp,
                          input logic [NB-1:0] inj);
    logic [NB-1:0] m;
    lock_bits = lk; wp_n = wp; inject = inj; vpp_ok = 1'b1;
    m = exp_mask(lk, wp);
    arm_run();
    send_cmd(8'h30);
    send_cmd(8'hD0);
    chk(ready_out == 1'b0, "R1 ready low after confirm", 64'(ready_out), 64'd0);
    wait_ready();
    chk(order_err == 0, "R2 ascending single-step order", 64'(order_err), 64'd0);
    chk(started == m, "R3 started blocks", started, m);
    chk(fail_map == (m & inj), "R4 fail map", fail_map, m & inj);
    chk(status == exp_stat(1'b1, |(m & inj), 1'b0, 1'b0), "R7 final status",
        64'(status), 64'(exp_stat(1'b1, |(m & inj), 1'b0, 1'b0)));
  endtask

  task automatic finish_tb();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_tb();
  end

  initial begin
    logic [NB-1:0] keep;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(status == 8'h80, "R9 reset status", 64'(status), 64'h80);
    chk(fail_map == '0, "R9 reset fail map", fail_map, 64'd0);

    // R1: confirm alone does nothing
    arm_run();
    send_cmd(8'hD0);
    repeat (3) @(negedge clk);
    chk(ready_out && started == '0, "R1 lone confirm ignored", started, 64'd0);

    // Random runs
    for (int i = 0; i < 6; i++) begin
      run_full({$urandom, $urandom}, 1'($urandom_range(0, 1)),
               {$urandom, $urandom} & {$urandom, $urandom});
      keep = fail_map;
      send_cmd(8'h50);
      chk(status == 8'h80, "R10 clear status", 64'(status), 64'h80);
      chk(fail_map == keep, "R10 fail map kept", fail_map, keep);
    end

    // Directed corners
    run_full({NB{1'b1}}, 1'b0, {NB{1'b1}});   // everything skipped
    run_full({NB{1'b1}}, 1'b1, {NB{1'b1}});   // protection off, all fail
    send_cmd(8'h50);
    run_full({1'b1, {(NB-1){1'b0}}}, 1'b0, '0);  // last block skipped, R9
    chk(fail_map == '0, "R4 fail map cleared on new walk", fail_map, 64'd0);

    // R5 invalid confirm
    arm_run();
    send_cmd(8'h30);
    send_cmd(8'h20);
    repeat (4) @(negedge clk);
    chk(status == 8'hB0, "R5 sequence error status", 64'(status), 64'hB0);
    chk(started == '0, "R5 nothing erased", started, 64'd0);
    send_cmd(8'h50);

    // R6 supply missing
    run_full('0, 1'b1, 64'h1);
    send_cmd(8'h50);
    keep = fail_map;
    vpp_ok = 1'b0;
    arm_run();
    send_cmd(8'h30);
    send_cmd(8'hD0);
    repeat (4) @(negedge clk);
    chk(status == 8'hA8, "R6 supply error status", 64'(status), 64'hA8);
    chk(started == '0 && fail_map == keep, "R6 nothing erased, map kept",
        fail_map, keep);
    vpp_ok = 1'b1;
    send_cmd(8'h50);

    // R8 commands during the walk are ignored
    lock_bits = 64'h00FF_0000_0000_F00F; wp_n = 1'b0;
    inject = 64'h0000_0100_0000_0010;
    arm_run();
    send_cmd(8'h30);
    send_cmd(8'hD0);
    send_cmd(8'hB0);
    send_cmd(8'h50);
    send_cmd(8'h30);
    send_cmd(8'hD0);
    chk(ready_out == 1'b0, "R8 still busy after suspend code", 64'(ready_out), 64'd0);
    wait_ready();
    chk(started == exp_mask(lock_bits, 1'b0), "R8 walk unchanged", started,
        exp_mask(lock_bits, 1'b0));
    chk(status == 8'hA0, "R8 mid-walk clear ignored", 64'(status), 64'hA0);
    chk(fail_map == (inject & ~lock_bits), "R8 fail map", fail_map, inject & ~lock_bits);
    repeat (3) @(negedge clk);
    chk(ready_out == 1'b1, "R8 no second walk launched", 64'(ready_out), 64'd1);

    finish_tb();
  end
endmodule